// File: doc/BRIEF.md
# Byte-Serial Register Bus Command Decoder

This block is the device end of a register bus framed by a chip select. While the select is high, the host sends bytes one at a time. Each byte arrives with a one-cycle strobe from a serialiser that is outside this block. The first bytes of a frame form a header. The top bit of the first header byte sets the header length and the target space:

- **Short header (2 bytes):** reaches a small command space.
- **Long header (4 bytes):** reaches a wider register/memory space.

Every byte after the header is a data byte of a burst that runs until the select drops.

For each data byte the block drives one write or read pulse toward the external register file, with an address that steps up after every byte. There is one exception: a chosen FIFO data-port address holds still, so a whole packet can stream into the port in one frame. Reads are fetched ahead, so the byte the host shifts out during each data byte is already on `tx_byte`. A short header of all zeros is special: it returns a fixed 32-bit identification word, most significant byte first, and does not touch the register file.

Top module: `sbus_cmd_decoder`

## Requirements
- R1: After reset `tx_byte` is 0x00 and no write or read pulse is driven.
- R2: A first header byte with bit 7 clear starts a 2-byte header. Bit 6 of that byte selects write (1) or read (0). Bits 5:0 give the starting command register. The second byte is ignored, except for the identification case in R4.
- R3: A first header byte with bit 7 set starts a 4-byte header. Bit 6 selects write. Header byte 1 gives address bits 15:8 and header byte 2 gives bits 7:0. First-byte bits 5:0 and header byte 3 are ignored. The address is truncated to `MEM_AW` bits.
- R4: A short header of 0x00 followed by 0x00 makes the read data bytes return 0x04, 0x02, 0x02, 0x00, repeating every four bytes, with no register read pulse. A short read header of 0x00 followed by any non-zero byte reads command register 0.
- R5: In a write burst, each data byte produces exactly one write pulse in the next clock cycle, carrying that byte and the current address. The address then rises by one, wrapping at the width of the space.
- R6: In a read burst, the byte for each data slot is on `tx_byte` when that slot's strobe is given, provided strobes are at least 4 clocks apart. Successive slots return consecutive addresses, wrapping at the width of the space. Each slot issues one read pulse.
- R7: In the memory space, the address does not advance while it equals `FIFO_ADDR`, for reads and for writes.
- R8: Dropping the select before the header is complete causes no write or read pulse, and the next frame decodes a fresh header.
- R9: Strobes seen while the select is low cause no access. The select falling ends a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Frame select, high during a frame |
| byte_stb | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte, valid with `byte_stb` |
| tx_byte | output | 8 | Byte the host shifts out during the next data slot |
| cmd_we | output | 1 | Command-space write pulse |
| cmd_re | output | 1 | Command-space read pulse |
| cmd_addr | output | CMD_AW | Command-space register number |
| cmd_rdata | input | 8 | Command-space read data, one cycle after `cmd_re` |
| mem_we | output | 1 | Memory-space write pulse |
| mem_re | output | 1 | Memory-space read pulse |
| mem_addr | output | MEM_AW | Memory-space address |
| mem_rdata | input | 8 | Memory-space read data, one cycle after `mem_re` |
| wdata | output | 8 | Write data for either space |

## Verification
The bench builds the decoder with `CMD_AW=6` and `MEM_AW=8`, keeping `FIFO_ADDR` at 0x48. With these values the bench models both spaces as small arrays with synchronous reads.

Every command register is written through its own frame, and the whole command space is read back in one burst that wraps from register 63 to register 0. In the memory space, a 200-byte burst wraps past the top of the address range, and bursts that run into the FIFO address show it holding.

After every write phase, the full contents of both modelled spaces are compared against expectations that the bench computes by address arithmetic.

// File: rtl/sbus_dec_pkg.sv
package sbus_dec_pkg;

  // Width of the address field carried by a long header.
  localparam int HDR_ADDR_W = 16;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_RD  = 2'd1,
    PH_WR  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SP_CMD = 2'd0,
    SP_MEM = 2'd1,
    SP_ID  = 2'd2
  } space_t;

  typedef struct packed {
    space_t                space;
    logic                  wr;
    logic [HDR_ADDR_W-1:0] addr;
  } hdr_t;

endpackage

// File: rtl/sbus_hdr_capture.sv
module sbus_hdr_capture
  import sbus_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       active,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  output logic       hdr_done,
  output hdr_t       hdr_out
);

  logic [1:0] idx;
  logic [7:0] b0;
  logic [7:0] b1;
  logic [7:0] b2;
  logic       last_byte;
  hdr_t       nxt;

  // A short header ends on its second byte; a long one on its fourth.
  assign last_byte = ((idx == 2'd1) && !b0[7]) || (idx == 2'd3);

  always_comb begin
    nxt       = '0;
    nxt.wr    = b0[6];
    nxt.space = SP_CMD;
    if (b0[7]) begin
      nxt.space = SP_MEM;
      nxt.addr  = {b1, b2};
    end else if ((b0 == 8'h00) && (byte_in == 8'h00)) begin
      nxt.space = SP_ID;
    end else begin
      nxt.addr  = {{(HDR_ADDR_W-6){1'b0}}, b0[5:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= 2'd0;
      b0       <= 8'h00;
      b1       <= 8'h00;
      b2       <= 8'h00;
      hdr_done <= 1'b0;
      hdr_out  <= '0;
    end else begin
      hdr_done <= 1'b0;
      if (!sel || !active) begin
        idx <= 2'd0;
      end else if (byte_stb) begin
        case (idx)
          2'd0:    b0 <= byte_in;
          2'd1:    b1 <= byte_in;
          2'd2:    b2 <= byte_in;
          default: ;
        endcase
        if (last_byte) begin
          idx      <= 2'd0;
          hdr_done <= 1'b1;
          hdr_out  <= nxt;
        end else begin
          idx <= idx + 2'd1;
        end
      end
    end
  end

  // R8
  hdr_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !hdr_done);

  // R2
  hdr_src_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> ($past(byte_stb) && $past(sel) && $past(active)));

endmodule

// File: rtl/sbus_addr_gen.sv
module sbus_addr_gen #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] HOLD_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          hold_en,
  output logic [AW-1:0] addr
);

  logic at_hold;

  assign at_hold = hold_en && (addr == HOLD_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (inc && !at_hold) begin
      addr <= addr + 1'b1;
    end
  end

  // R5
  addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(addr));

endmodule

// File: rtl/sbus_rd_path.sv
module sbus_rd_path
  import sbus_dec_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h04020200
) (
  input  logic       clk,
  input  logic       rst,
  input  space_t     space,
  input  logic       issue,
  input  logic       id_load,
  input  logic       id_adv,
  input  logic [7:0] cmd_rdata,
  input  logic [7:0] mem_rdata,
  output logic [7:0] tx_byte
);

  logic       pend;
  logic [1:0] id_idx;

  // Most significant byte of the identification word comes out first.
  function automatic logic [7:0] id_byte(input logic [1:0] k);
    logic [4:0]  amt;
    logic [31:0] sh;
    amt = {2'd3 - k, 3'b000};
    sh  = ID_WORD >> amt;
    return sh[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      id_idx  <= 2'd0;
      tx_byte <= 8'h00;
    end else begin
      pend <= issue;
      if (id_load) begin
        id_idx  <= 2'd0;
        tx_byte <= id_byte(2'd0);
      end else if (id_adv) begin
        id_idx  <= id_idx + 2'd1;
        tx_byte <= id_byte(id_idx + 2'd1);
      end else if (pend) begin
        tx_byte <= (space == SP_MEM) ? mem_rdata : cmd_rdata;
      end
    end
  end

  // R4
  id_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    !(issue && (space == SP_ID)));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && !id_load && !id_adv) |=> $stable(tx_byte));

endmodule

// File: rtl/sbus_cmd_decoder.sv
module sbus_cmd_decoder
  import sbus_dec_pkg::*;
#(
  parameter int                CMD_AW    = 6,
  parameter int                MEM_AW    = 16,
  parameter logic [MEM_AW-1:0] FIFO_ADDR = 'h48,
  parameter logic [31:0]       ID_WORD   = 32'h04020200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  output logic [7:0]        tx_byte,
  output logic              cmd_we,
  output logic              cmd_re,
  output logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        wdata
);

  localparam int ADDR_W = (MEM_AW > CMD_AW) ? MEM_AW : CMD_AW;
  localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(FIFO_ADDR);

  phase_t              phase;
  space_t              space_q;
  hdr_t                hdr;
  logic                hdr_done;
  logic                id_load;
  logic                id_adv;
  logic                load;
  logic                inc;
  logic                wr_bump;
  logic [ADDR_W-1:0]   addr;

  sbus_hdr_capture i_hdr (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .active   (phase == PH_HDR),
    .byte_stb (byte_stb),
    .byte_in  (byte_in),
    .hdr_done (hdr_done),
    .hdr_out  (hdr)
  );

  assign load    = sel && (phase == PH_HDR) && hdr_done;
  assign wr_bump = cmd_we || mem_we;
  assign inc     = (sel && byte_stb && (phase == PH_RD) && (space_q != SP_ID))
                 || wr_bump;

  sbus_addr_gen #(
    .AW        (ADDR_W),
    .HOLD_ADDR (HOLD_A)
  ) i_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (hdr.addr[ADDR_W-1:0]),
    .inc      (inc),
    .hold_en  (space_q == SP_MEM),
    .addr     (addr)
  );

  assign cmd_addr = addr[CMD_AW-1:0];
  assign mem_addr = addr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_HDR;
      space_q <= SP_CMD;
      cmd_we  <= 1'b0;
      cmd_re  <= 1'b0;
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      id_load <= 1'b0;
      id_adv  <= 1'b0;
      wdata   <= 8'h00;
    end else begin
      cmd_we  <= 1'b0;
      cmd_re  <= 1'b0;
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      id_load <= 1'b0;
      id_adv  <= 1'b0;
      if (!sel) begin
        phase <= PH_HDR;
      end else begin
        case (phase)
          PH_HDR: begin
            if (hdr_done) begin
              space_q <= hdr.space;
              phase   <= hdr.wr ? PH_WR : PH_RD;
              if (!hdr.wr) begin
                case (hdr.space)
                  SP_MEM:  mem_re  <= 1'b1;
                  SP_ID:   id_load <= 1'b1;
                  default: cmd_re  <= 1'b1;
                endcase
              end
            end
          end
          PH_RD: begin
            if (byte_stb) begin
              case (space_q)
                SP_MEM:  mem_re <= 1'b1;
                SP_ID:   id_adv <= 1'b1;
                default: cmd_re <= 1'b1;
              endcase
            end
          end
          PH_WR: begin
            if (byte_stb) begin
              wdata <= byte_in;
              if (space_q == SP_MEM) mem_we <= 1'b1;
              else                   cmd_we <= 1'b1;
            end
          end
          default: phase <= PH_HDR;
        endcase
      end
    end
  end

  sbus_rd_path #(
    .ID_WORD (ID_WORD)
  ) i_rd (
    .clk       (clk),
    .rst       (rst),
    .space     (space_q),
    .issue     (cmd_re || mem_re),
    .id_load   (id_load),
    .id_adv    (id_adv),
    .cmd_rdata (cmd_rdata),
    .mem_rdata (mem_rdata),
    .tx_byte   (tx_byte)
  );

  // R9
  idle_access_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !(cmd_we || cmd_re || mem_we || mem_re));

  // R6
  access_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_we, cmd_re, mem_we, mem_re}));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && byte_stb && (phase == PH_WR)) |=> (cmd_we || mem_we));

  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (mem_addr != FIFO_ADDR)) |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

  // R7
  fifo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (mem_addr == FIFO_ADDR)) |=> $stable(mem_addr));

endmodule

// File: tb/test_sbus_cmd_decoder.sv
module test_sbus_cmd_decoder;

  localparam int CMD_AW = 6;
  localparam int MEM_AW = 8;
  localparam int NCMD   = 1 << CMD_AW;
  localparam int NMEM   = 1 << MEM_AW;
  localparam logic [7:0] FIFO_A = 8'h48;
  localparam int GAP    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic byte_stb = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] tx_byte;
  logic cmd_we, cmd_re, mem_we, mem_re;
  logic [CMD_AW-1:0] cmd_addr;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] cmd_rdata, mem_rdata, wdata;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;

  logic [7:0] cmd_m   [NCMD];
  logic [7:0] mem_m   [NMEM];
  logic [7:0] cmd_exp [NCMD];
  logic [7:0] mem_exp [NMEM];

  always #5 clk = ~clk;

  sbus_cmd_decoder #(
    .CMD_AW    (CMD_AW),
    .MEM_AW    (MEM_AW),
    .FIFO_ADDR (FIFO_A)
  ) i_sbus_cmd_decoder (
    .clk (clk), .rst (rst), .sel (sel), .byte_stb (byte_stb), .byte_in (byte_in),
    .tx_byte (tx_byte), .cmd_we (cmd_we), .cmd_re (cmd_re), .cmd_addr (cmd_addr),
    .cmd_rdata (cmd_rdata), .mem_we (mem_we), .mem_re (mem_re), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .wdata (wdata)
  );

  // Register-file models with one-cycle synchronous read.
  always @(posedge clk) begin
    if (cmd_we) cmd_m[cmd_addr] <= wdata;
    if (cmd_re) cmd_rdata <= cmd_m[cmd_addr];
    if (mem_we) mem_m[mem_addr] <= wdata;
    if (mem_re) mem_rdata <= mem_m[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (cmd_we || mem_we) wr_cnt <= wr_cnt + 1;
      if (cmd_re || mem_re) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] seen);
    repeat (GAP) @(negedge clk);
    seen = tx_byte;
    byte_in = b;
    byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic fbegin;
    @(negedge clk);
    sel = 1'b1;
  endtask

  task automatic fend;
    repeat (GAP) @(negedge clk);
    sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd_hdr(input logic [5:0] r, input logic wr, input logic [7:0] second);
    logic [7:0] s;
    xfer({1'b0, wr, r}, s);
    xfer(second, s);
  endtask

  task automatic mem_hdr(input logic [7:0] a, input logic wr);
    logic [7:0] s;
    xfer({1'b1, wr, 6'h15}, s);
    xfer(8'h00, s);
    xfer(a, s);
    xfer(8'h9C, s);
  endtask

  task automatic cmp_spaces(input string rq);
    for (int i = 0; i < NCMD; i++) check(rq, cmd_m[i], cmd_exp[i]);
    for (int i = 0; i < NMEM; i++) check(rq, mem_m[i], mem_exp[i]);
  endtask

  task automatic mem_wr_burst(input logic [7:0] start, input int n, input int seed);
    logic [7:0] a;
    logic [7:0] v;
    logic [7:0] s;
    int w0;
    a = start;
    fbegin;
    mem_hdr(start, 1'b1);
    w0 = wr_cnt;
    for (int i = 0; i < n; i++) begin
      v = 8'(seed + i * 11);
      xfer(v, s);
      mem_exp[a] = v;
      if (a != FIFO_A) a = a + 8'd1;
    end
    fend;
    check("R5 write pulse count", wr_cnt - w0, n);
  endtask

  task automatic mem_rd_burst(input logic [7:0] start, input int n, input string rq);
    logic [7:0] a;
    logic [7:0] s;
    int r0;
    a = start;
    fbegin;
    r0 = rd_cnt;
    mem_hdr(start, 1'b0);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, s);
      check(rq, s, mem_exp[a]);
      if (a != FIFO_A) a = a + 8'd1;
    end
    fend;
    check("R6 read pulse count", rd_cnt - r0, n + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [5:0] ca;
    int w0;
    int r0;
    for (int i = 0; i < NCMD; i++) begin
      cmd_m[i] = 8'(i * 5 + 1);
      cmd_exp[i] = 8'(i * 5 + 1);
    end
    for (int i = 0; i < NMEM; i++) begin
      mem_m[i] = 8'(i * 3 + 17);
      mem_exp[i] = 8'(i * 3 + 17);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 tx_byte", tx_byte, 8'h00);
    check("R1 strobes", {cmd_we, cmd_re, mem_we, mem_re}, 4'h0);
    check("R1 no access", wr_cnt + rd_cnt, 0);

    // R2 one write frame per command register, second header byte varied
    for (int r = 0; r < NCMD; r++) begin
      logic [7:0] v;
      v = 8'(r * 13 + 7);
      w0 = wr_cnt;
      fbegin;
      cmd_hdr(6'(r), 1'b1, 8'(r ^ 8'h5A));
      xfer(v, s);
      fend;
      cmd_exp[r] = v;
      check("R2 single write count", wr_cnt - w0, 1);
      check("R2 register written", cmd_m[r], v);
    end

    // R5 write burst wrapping across the top of the command space
    ca = 6'h3E;
    w0 = wr_cnt;
    fbegin;
    cmd_hdr(ca, 1'b1, 8'h33);
    for (int i = 0; i < 4; i++) begin
      xfer(8'(8'hE0 + i), s);
      cmd_exp[ca] = 8'(8'hE0 + i);
      ca = ca + 6'd1;
    end
    fend;
    check("R5 cmd burst count", wr_cnt - w0, 4);
    cmp_spaces("R5 cmd wrap write");

    // R6 read the whole command space from register 1, wrapping to 0
    ca = 6'h01;
    fbegin;
    cmd_hdr(ca, 1'b0, 8'hC3);
    for (int i = 0; i < NCMD; i++) begin
      xfer(8'hFF, s);
      check("R6 cmd read burst", s, cmd_exp[ca]);
      ca = ca + 6'd1;
    end
    fend;

    // R4 identification word, no register reads
    r0 = rd_cnt;
    fbegin;
    cmd_hdr(6'h00, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] idw;
      idw = 32'h04020200 >> (8 * (3 - (i % 4)));
      xfer(8'hFF, s);
      check("R4 id byte", s, idw[7:0]);
    end
    fend;
    check("R4 id no read pulse", rd_cnt - r0, 0);

    // R4 non-zero second byte reads command register 0
    fbegin;
    cmd_hdr(6'h00, 1'b0, 8'h01);
    xfer(8'hFF, s);
    fend;
    check("R4 reg0 not id", s, cmd_exp[0]);

    // R3 R5 long write burst wrapping the memory space
    mem_wr_burst(8'h50, 200, 9);
    cmp_spaces("R3 mem burst write");
    mem_rd_burst(8'h50, 200, "R6 mem read burst");

    // R7 FIFO address holds for writes and reads
    mem_wr_burst(8'h46, 6, 100);
    cmp_spaces("R7 fifo write hold");
    mem_rd_burst(8'h47, 4, "R7 fifo read hold");
    mem_rd_burst(8'h49, 2, "R7 after fifo");

    // R8 deselect inside a long and a short header
    w0 = wr_cnt;
    r0 = rd_cnt;
    fbegin;
    xfer(8'hC0, s);
    xfer(8'h00, s);
    fend;
    fbegin;
    xfer(8'h45, s);
    fend;
    check("R8 aborted header writes", wr_cnt - w0, 0);
    check("R8 aborted header reads", rd_cnt - r0, 0);
    fbegin;
    cmd_hdr(6'h05, 1'b0, 8'h00);
    xfer(8'hFF, s);
    fend;
    check("R8 fresh header after abort", s, cmd_exp[5]);

    // R9 strobes with select low are ignored
    w0 = wr_cnt;
    fbegin;
    cmd_hdr(6'h0A, 1'b1, 8'h00);
    xfer(8'h6D, s);
    fend;
    cmd_exp[10] = 8'h6D;
    for (int i = 0; i < 3; i++) xfer(8'(8'h90 + i), s);
    repeat (3) @(negedge clk);
    check("R9 writes with select low", wr_cnt - w0, 1);
    check("R9 register kept", cmd_m[10], 8'h6D);
    cmp_spaces("R9 spaces unchanged");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule